// File: doc/BRIEF.md
# Dual-Line Secondary Interrupt Bank

This block gathers up to 32 interrupt sources (24 by default) and presents them to two independent host interrupt lines. Every source passes through a synchronizer and an edge detector. The rising and falling edge enables for all sources sit in one shared edge-control register. A detected event raises the source's status bit on both lines in the same cycle. From then on each line keeps its own status register and its own mask register, and it acknowledges and masks the bit without reference to the other line.

A byte-wide register port with one cycle of read latency reaches every register. A control register picks the acknowledge style. With clear-on-read, reading a status byte acknowledges it. Otherwise software writes ones to the status byte to clear bits. The control register also sets whether a second event that arrives while a bit is still pending is kept or dropped. A test register forces status bits directly. Each line drives a registered, active-low pending output.

Top module: `irqb_top`

## Requirements
- R1: A source event sets its status bit on line 0 and line 1 in the same cycle, and clearing a bit on one line leaves the other line's copy unchanged.
- R2: The edge-control register sits at addresses 0x10 to 0x17. Source i uses byte 0x10+(i>>2) at offset o=(i&3)*2. Bit o+1 enables the rising edge and bit o enables the falling edge. With both bits set, either edge counts. A pin change shows in the status register at the third rising clock edge after the change.
- R3: After reset every edge-control bit is 0. A source whose two edge bits are both 0 never sets status from its pin.
- R4: The control register is at 0x1C. When bit 0 is 1 (clear-on-read), reading a status byte returns its value and clears the bits that were read, and writes to the status byte have no effect.
- R5: When control bit 0 is 0, writing 1s to a status byte clears those bits, writing 0s leaves bits unchanged, and reads do not clear.
- R6: When control bit 1 is 0, a second event on a pending bit is kept, and the bit is set again straight after the first clear. When control bit 1 is 1, such an event is dropped.
- R7: A mask bit of 1 disables its source on that line. Every mask bit is 1 after reset, and the mask bytes read back what was written.
- R8: Status and mask are little-endian. Line 0 status is at 0x00 to 0x03, line 0 mask at 0x04 to 0x07, line 1 status at 0x08 to 0x0B and line 1 mask at 0x0C to 0x0F. Byte b holds sources 8b to 8b+7, with source 8b+k at bit k.
- R9: Writing 1s to the test bytes at 0x18 to 0x1B sets the matching status bits on both lines, whatever the edge-control setting.
- R10: irq_n[l] is driven low one cycle after the status of line l has an unmasked bit set. It is high during reset and whenever the line has no unmasked pending bit.
- R11: An event that sets a status bit in the same cycle as a clear-on-read of that byte leaves the bit set. That read returns the value from before the event.
- R12: Read data appears on rdata one clock after rd_en. Unmapped bytes read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | N | Asynchronous interrupt source pins |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid one clock after rd_en |
| irq_n | output | 2 | Active-low pending output per host line |

## Verification
Two functions can fall in the same cycle: an edge event reaching a status bit, and a clear-on-read of the byte that holds it. The bench changes a pin and then issues the read so that it lands on the third clock edge after the change, which is the edge where the event reaches status. The result is judged correct when that read returns the old value with the bit clear and the next read returns the bit set. In clear-on-write mode, the interaction between a buffered second event and a clear is judged in the same way, by reading the status back after each clear.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  localparam int unsigned ADDR_W = 5;

  // region decoded from addr[4:2]
  typedef enum logic [2:0] {
    RG_STAT0   = 3'd0,
    RG_MASK0   = 3'd1,
    RG_STAT1   = 3'd2,
    RG_MASK1   = 3'd3,
    RG_EDGE_LO = 3'd4,
    RG_EDGE_HI = 3'd5,
    RG_SET     = 3'd6,
    RG_CTRL    = 3'd7
  } region_e;

  localparam int unsigned CTRL_COR_BIT  = 0;
  localparam int unsigned CTRL_PDIS_BIT = 1;
endpackage

// File: rtl/irqb_edge.sv
module irqb_edge #(
  parameter int N = 24
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   pins,
  input  logic [2*N-1:0] cfg,
  output logic [N-1:0]   ev
);
  logic [N-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pins;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  // source i: falling enable at cfg[2i], rising enable at cfg[2i+1]
  for (genvar i = 0; i < N; i++) begin : g_src
    assign ev[i] = (cfg[2*i+1] &  s2_q[i] & ~prev_q[i]) |
                   (cfg[2*i]   & ~s2_q[i] &  prev_q[i]);
  end
endmodule

// File: rtl/irqb_line.sv
module irqb_line #(
  parameter int N  = 24,
  parameter int NB = 3,
  parameter int NP = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] ev,
  input  logic          stat_wr,
  input  logic          stat_rd,
  input  logic          mask_wr,
  input  logic [1:0]    bsel,
  input  logic [7:0]    wdata,
  input  logic          cor,
  input  logic          pdis,
  output logic [NP-1:0] stat,
  output logic [NP-1:0] mask,
  output logic          irq_n
);
  localparam logic [NP-1:0] VALID = NP'((33'd1 << N) - 33'd1);

  logic [NP-1:0] pend_q;
  logic [NP-1:0] clr;

  always_comb begin
    clr = '0;
    for (int b = 0; b < NB; b++) begin
      if (bsel == 2'(b)) begin
        if (stat_wr && !cor) clr[8*b +: 8] = wdata;
        if (stat_rd && cor)  clr[8*b +: 8] = 8'hFF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat   <= '0;
      pend_q <= '0;
      mask   <= '1;
      irq_n  <= 1'b1;
    end else begin
      // new event wins over a clear; a buffered event refills the bit on clear
      stat   <= ((stat & ~clr) | (pend_q & clr) | ev) & VALID;
      pend_q <= ((pend_q & ~clr) | (ev & stat & ~clr & {NP{~pdis}})) & VALID;
      for (int b = 0; b < NB; b++) begin
        if (mask_wr && bsel == 2'(b)) mask[8*b +: 8] <= wdata;
      end
      irq_n  <= ~|(stat & ~mask);
    end
  end
endmodule

// File: rtl/irqb_top.sv
module irqb_top
  import irqb_pkg::*;
#(
  parameter int N = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        src_in,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata,
  output logic [1:0]          irq_n
);
  localparam int NB = (N + 7) / 8;
  localparam int NP = NB * 8;
  localparam int NE = (2 * N + 7) / 8;

  region_e        rg;
  logic           cor_q, pdis_q;
  logic [NE*8-1:0] edge_q;
  logic [N-1:0]   ev_n;
  logic [NP-1:0]  force_v, ev_all;
  logic [NP-1:0]  stat_v [2];
  logic [NP-1:0]  mask_v [2];

  assign rg = region_e'(addr[4:2]);

  irqb_edge #(.N(N)) u_edge (
    .clk(clk), .rst(rst), .pins(src_in), .cfg(edge_q[2*N-1:0]), .ev(ev_n)
  );

  always_comb begin
    force_v = '0;
    for (int b = 0; b < NB; b++) begin
      if (wr_en && rg == RG_SET && addr[1:0] == 2'(b)) force_v[8*b +: 8] = wdata;
    end
  end

  assign ev_all = NP'(ev_n) | force_v;

  for (genvar l = 0; l < 2; l++) begin : g_line
    localparam region_e SRG = (l == 0) ? RG_STAT0 : RG_STAT1;
    localparam region_e MRG = (l == 0) ? RG_MASK0 : RG_MASK1;
    irqb_line #(.N(N), .NB(NB), .NP(NP)) u_line (
      .clk(clk), .rst(rst), .ev(ev_all),
      .stat_wr(wr_en && rg == SRG),
      .stat_rd(rd_en && rg == SRG),
      .mask_wr(wr_en && rg == MRG),
      .bsel(addr[1:0]), .wdata(wdata),
      .cor(cor_q), .pdis(pdis_q),
      .stat(stat_v[l]), .mask(mask_v[l]), .irq_n(irq_n[l])
    );
  end

  function automatic logic [7:0] pick(input logic [NP-1:0] v, input logic [1:0] i);
    pick = '0;
    for (int b = 0; b < NB; b++) if (i == 2'(b)) pick = v[8*b +: 8];
  endfunction

  function automatic logic [7:0] pick_edge(input logic [NE*8-1:0] v, input logic [2:0] i);
    pick_edge = '0;
    for (int b = 0; b < NE; b++) if (i == 3'(b)) pick_edge = v[8*b +: 8];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cor_q  <= 1'b0;
      pdis_q <= 1'b0;
      edge_q <= '0;
    end else if (wr_en) begin
      if (rg == RG_CTRL) begin
        cor_q  <= wdata[CTRL_COR_BIT];
        pdis_q <= wdata[CTRL_PDIS_BIT];
      end
      if (rg == RG_EDGE_LO || rg == RG_EDGE_HI) begin
        for (int b = 0; b < NE; b++)
          if (addr[2:0] == 3'(b)) edge_q[8*b +: 8] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (rg)
        RG_STAT0:               rdata <= pick(stat_v[0], addr[1:0]);
        RG_MASK0:               rdata <= pick(mask_v[0], addr[1:0]);
        RG_STAT1:               rdata <= pick(stat_v[1], addr[1:0]);
        RG_MASK1:               rdata <= pick(mask_v[1], addr[1:0]);
        RG_EDGE_LO, RG_EDGE_HI: rdata <= pick_edge(edge_q, addr[2:0]);
        RG_CTRL:                rdata <= {6'd0, pdis_q, cor_q};
        default:                rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irqb_chk.sv
module irqb_chk #(
  parameter int NP  = 24,
  parameter int NEB = 48
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic [2:0]     sel,
  input logic [1:0]     irq_n,
  input logic [NP-1:0]  stat0,
  input logic [NP-1:0]  stat1,
  input logic [NP-1:0]  mask0,
  input logic [NP-1:0]  mask1,
  input logic [NEB-1:0] edge_cfg
);
  // R1: a bit newly set on one line is set on the other line too
  a_r1_lines_together: assert property (@(posedge clk) disable iff (rst)
    ((stat0 & ~$past(stat0) & ~stat1) == '0) && ((stat1 & ~$past(stat1) & ~stat0) == '0));

  // R7: reset leaves every mask bit at 1
  a_r7_mask_reset: assert property (@(posedge clk)
    rst |=> ((&mask0) && (&mask1)));

  // R3: with all edge bits clear and no test write, no bit rises
  a_r3_quiet_disabled: assert property (@(posedge clk) disable iff (rst)
    ($past(edge_cfg) == '0 && !$past(wr_en && sel == 3'd6))
      |-> ((stat0 & ~$past(stat0)) == '0));

  // R10: a low pending output needs an unmasked pending bit one cycle before
  a_r10_line0_low: assert property (@(posedge clk) disable iff (rst)
    !irq_n[0] |-> $past(|(stat0 & ~mask0)));

  a_r10_line1_low: assert property (@(posedge clk) disable iff (rst)
    !irq_n[1] |-> $past(|(stat1 & ~mask1)));
endmodule

bind irqb_top irqb_chk #(.NP(NP), .NEB(NE*8)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .sel(addr[4:2]), .irq_n(irq_n),
  .stat0(stat_v[0]), .stat1(stat_v[1]), .mask0(mask_v[0]), .mask1(mask_v[1]),
  .edge_cfg(edge_q)
);

// File: tb/irqb_top_test.sv
module irqb_top_test;
  localparam int N = 24;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] src_in;
  logic         wr_en, rd_en;
  logic [4:0]   addr;
  logic [7:0]   wdata;
  logic [7:0]   rdata;
  logic [1:0]   irq_n;

  int checks = 0;
  int errors = 0;

  localparam logic [4:0] A_STAT0 = 5'h00, A_MASK0 = 5'h04, A_STAT1 = 5'h08,
                         A_MASK1 = 5'h0C, A_EDGE = 5'h10, A_SET = 5'h18, A_CTRL = 5'h1C;

  irqb_top #(.N(N)) uut (
    .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_check(input string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R10 reset irq_n", {6'd0, irq_n}, 8'h03);
    rd_check("R7 mask0 reset", A_MASK0 + 5'd0, 8'hFF);
    rd_check("R7 mask1 reset", A_MASK1 + 5'd2, 8'hFF);
    rd_check("R12 stat0 reset", A_STAT0, 8'h00);
    rd_check("R12 ctrl reset", A_CTRL, 8'h00);
    rd_check("R3 edge reset", A_EDGE + 5'd1, 8'h00);
    rd_check("R12 unmapped", A_STAT0 + 5'd3, 8'h00);
  endtask

  task automatic t_disabled;
    src_in[5] = 1'b1; idle(5);
    src_in[5] = 1'b0; idle(5);
    rd_check("R3 line0 no set", A_STAT0, 8'h00);
    rd_check("R3 line1 no set", A_STAT1, 8'h00);
  endtask

  task automatic t_rise;
    wr(A_EDGE + 5'd1, 8'h08);          // source 5 rising
    src_in[5] = 1'b1; idle(5);
    rd_check("R2 rise line0", A_STAT0, 8'h20);
    rd_check("R1 rise line1", A_STAT1, 8'h20);
    src_in[5] = 1'b0; idle(5);         // falling not enabled
    wr(A_STAT0, 8'h20);
    rd_check("R5 w1c line0", A_STAT0, 8'h00);
    rd_check("R1 line1 kept", A_STAT1, 8'h20);
    rd_check("R5 read no clear", A_STAT1, 8'h20);
    wr(A_STAT1, 8'h00);
    rd_check("R5 zero write keeps", A_STAT1, 8'h20);
    wr(A_STAT1, 8'h20);
    rd_check("R1 line1 cleared", A_STAT1, 8'h00);
  endtask

  task automatic t_fall;
    wr(A_EDGE + 5'd2, 8'h10);          // source 10 falling
    rd_check("R2 edge readback", A_EDGE + 5'd2, 8'h10);
    src_in[10] = 1'b1; idle(5);
    rd_check("R2 rise ignored", A_STAT0 + 5'd1, 8'h00);
    src_in[10] = 1'b0; idle(5);
    rd_check("R8 fall byte1 bit2", A_STAT0 + 5'd1, 8'h04);
  endtask

  task automatic t_mask;
    check("R7 masked irq_n", {6'd0, irq_n}, 8'h03);
    wr(A_MASK1 + 5'd1, 8'hFB);
    idle(2);
    check("R10 line1 low", {6'd0, irq_n}, 8'h01);
    rd_check("R7 mask readback", A_MASK1 + 5'd1, 8'hFB);
    wr(A_STAT1 + 5'd1, 8'h04);
    idle(2);
    check("R10 line1 idle", {6'd0, irq_n}, 8'h03);
    wr(A_STAT0 + 5'd1, 8'h04);
    wr(A_MASK1 + 5'd1, 8'hFF);
  endtask

  task automatic t_buffer;
    wr(A_EDGE + 5'd4, 8'h0C);          // source 17 both edges
    src_in[17] = 1'b1; idle(5);
    src_in[17] = 1'b0; idle(5);
    rd_check("R8 byte2 bit1", A_STAT0 + 5'd2, 8'h02);
    wr(A_STAT0 + 5'd2, 8'h02);
    rd_check("R6 buffered refill", A_STAT0 + 5'd2, 8'h02);
    wr(A_STAT0 + 5'd2, 8'h02);
    rd_check("R6 second clear", A_STAT0 + 5'd2, 8'h00);
    wr(A_CTRL, 8'h02);
    src_in[17] = 1'b1; idle(5);
    src_in[17] = 1'b0; idle(5);
    wr(A_STAT0 + 5'd2, 8'h02);
    rd_check("R6 dropped", A_STAT0 + 5'd2, 8'h00);
    repeat (3) wr(A_STAT1 + 5'd2, 8'h02);
    rd_check("R6 line1 clean", A_STAT1 + 5'd2, 8'h00);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_cor;
    wr(A_CTRL, 8'h01);
    src_in[17] = 1'b1; idle(5);
    rd_check("R4 cor first read", A_STAT0 + 5'd2, 8'h02);
    rd_check("R4 cor cleared", A_STAT0 + 5'd2, 8'h00);
    rd_check("R1 cor line1", A_STAT1 + 5'd2, 8'h02);
    rd_check("R4 cor line1 cleared", A_STAT1 + 5'd2, 8'h00);
    src_in[17] = 1'b0; idle(5);
    wr(A_STAT0 + 5'd2, 8'hFF);
    rd_check("R4 write ignored", A_STAT0 + 5'd2, 8'h02);
    rd_check("R4 line1 drain", A_STAT1 + 5'd2, 8'h02);
  endtask

  task automatic t_same_cycle;
    src_in[17] = 1'b1;
    idle(2);                           // read lands on third edge after change
    rd_check("R11 read returns old", A_STAT0 + 5'd2, 8'h00);
    rd_check("R11 bit stays set", A_STAT0 + 5'd2, 8'h02);
    rd_check("R11 line1", A_STAT1 + 5'd2, 8'h02);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_force;
    wr(A_SET, 8'h81);
    wr(A_SET + 5'd2, 8'h01);           // source 16, edges disabled
    rd_check("R9 force line0", A_STAT0, 8'h81);
    rd_check("R9 force line1", A_STAT1, 8'h81);
    rd_check("R9 force byte2", A_STAT0 + 5'd2, 8'h01);
    wr(A_MASK0, 8'h7F);
    idle(2);
    check("R10 forced unmasked", {6'd0, irq_n}, 8'h02);
    wr(A_STAT0, 8'hFF);
    idle(2);
    check("R10 released", {6'd0, irq_n}, 8'h03);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; src_in = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_rise();
    t_fall();
    t_mask();
    t_buffer();
    t_cor();
    t_same_cycle();
    t_force();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule